// File: doc/BRIEF.md
# Serial Four-Channel Wiper Register Loader

This block receives 10-bit frames over a three-wire serial link and keeps four 8-bit wiper settings. Each frame carries a 2-bit channel field followed by a data byte, both sent most significant bit first. The serial clock, the active-low select and the serial data are sampled by a much faster system clock through two-stage synchronizers. The block stores the byte when the select line returns high, but only if exactly ten serial clocks arrived while the select line was low.

An open-drain style output sends the previous contents of the 10-bit shift register back out while a new frame comes in, so several loaders can be chained on one select line. A strap input turns the serial path off when it is high. An active-low reset puts every wiper back at midscale. The block presents the four settings as a flat bus and does nothing with them beyond that.

Top module: `spiw_loader`

## Requirements
- R1: A frame is 10 bits shifted in MSB first on rising serial clock edges while `cs_n` is low: bits 9..8 are the channel field and bits 7..0 the data byte, D7 first.
- R2: Channel field value 0 writes `wiper_bus[7:0]`, 1 writes `[15:8]`, 2 writes `[23:16]` and 3 writes `[31:24]`.
- R3: A wiper changes only after `cs_n` rises at the end of a frame. After the tenth serial clock and before `cs_n` rises, every wiper keeps its old value.
- R4: If `cs_n` rises after any count of serial clocks other than 10 (for example 9 or 11), no wiper changes.
- R5: While `rst_n` is low, every wiper holds 8'h80 (midscale), and `sdo_drive_low` is 0.
- R6: While `if_sel` is 1, serial frames have no effect on any wiper and `sdo_drive_low` stays 0.
- R7: During a frame, `sdo_drive_low` shows the complement of the bit that was held in shift register bit 9 before each rising edge. This output changes after falling serial clock edges, so a downstream loader receives the previous 10-bit frame, MSB first.
- R8: `sdo_drive_low` is the only data output. It is 1 only to pull the line low. It is 0 whenever `cs_n` is high or the bit to send is 1.
- R9: A committed frame changes only the selected wiper. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low reset; sets all wipers to midscale |
| if_sel | input | 1 | Interface strap; the serial path works only when 0 |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| sdi | input | 1 | Serial data input |
| sdo_drive_low | output | 1 | Open-drain control: 1 pulls the chain output low, 0 releases it |
| wiper_bus | output | 32 | Four 8-bit wiper settings; channel 0 in bits 7..0 |

## Verification
The bench sends frames of 9 and 11 clocks. A loader that counts loosely, or that commits whatever sits in the shift register, would corrupt a wiper on those frames. It checks every wiper after the tenth clock but before the select rises, which catches a design that writes early. It sends back-to-back frames and compares the bits returned on the chain output with the earlier frame, so an output that is off by one bit position, or that changes on the wrong edge, shows up as a shifted value. It also holds the interface strap high during a frame and pulses reset after several writes, to confirm that nothing leaks through and that all wipers return to midscale.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int NCH     = 1 << ADDR_W;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  function automatic logic [DATA_W-1:0] midscale();
    return DATA_W'(1) << (DATA_W - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] frame_chan(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] frame_byte(input logic [FRAME_W-1:0] f);
    return f[DATA_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return (c == CNT_SAT) ? c : c + 1'b1;
  endfunction
endpackage

// File: rtl/spiw_sync.sv
module spiw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/spiw_frame_rx.sv
module spiw_frame_rx
  import spiw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cs_active,
  input  logic               cs_start,
  input  logic               cs_end,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sdi_s,
  output logic               commit,
  output logic [FRAME_W-1:0] frame,
  output logic               sdo_bit
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      sdo_bit <= 1'b1;
    end else if (!en) begin
      bit_cnt <= '0;
      sdo_bit <= 1'b1;
    end else if (cs_start) begin
      bit_cnt <= '0;
      sdo_bit <= shreg[FRAME_W-1];
    end else if (cs_active && sclk_rise) begin
      shreg   <= {shreg[FRAME_W-2:0], sdi_s};
      bit_cnt <= count_step(bit_cnt);
    end else if (cs_active && sclk_fall) begin
      sdo_bit <= shreg[FRAME_W-1];
    end
  end

  assign commit = en & cs_end & (bit_cnt == CNT_W'(FRAME_W));
  assign frame  = shreg;
endmodule

// File: rtl/spiw_wiper_bank.sv
module spiw_wiper_bank
  import spiw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     chan,
  input  logic [DATA_W-1:0]     value,
  output logic [NCH*DATA_W-1:0] wiper_bus
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] wreg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          wreg <= midscale();
      else if (we && chan == ADDR_W'(c))   wreg <= value;
    end
    assign wiper_bus[c*DATA_W +: DATA_W] = wreg;
  end
endmodule

// File: rtl/spiw_loader.sv
module spiw_loader
  import spiw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  if_sel,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  sdi,
  output logic                  sdo_drive_low,
  output logic [NCH*DATA_W-1:0] wiper_bus
);
  logic sclk_s, sclk_rise, sclk_fall;
  logic cs_s, cs_rise, cs_fall;
  logic sdi_s, sdi_rise, sdi_fall;
  logic cs_active, commit, sdo_bit;
  logic [FRAME_W-1:0] frame;

  spiw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s), .rise(sclk_rise), .fall(sclk_fall));
  spiw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s), .rise(cs_rise), .fall(cs_fall));
  spiw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s), .rise(sdi_rise), .fall(sdi_fall));

  assign cs_active = ~cs_s;

  spiw_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(~if_sel), .cs_active(cs_active),
    .cs_start(cs_fall), .cs_end(cs_rise), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .commit(commit),
    .frame(frame), .sdo_bit(sdo_bit));

  spiw_wiper_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(commit), .chan(frame_chan(frame)),
    .value(frame_byte(frame)), .wiper_bus(wiper_bus));

  assign sdo_drive_low = ~if_sel & cs_active & ~sdo_bit;

  logic unused_ok;
  assign unused_ok = &{1'b0, sclk_s, sdi_rise, sdi_fall};
endmodule

// File: rtl/spiw_checker.sv
module spiw_checker
  import spiw_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  if_sel,
  input logic                  sdo_drive_low,
  input logic                  cs_active,
  input logic                  sclk_fall,
  input logic                  cs_fall,
  input logic                  sdo_bit,
  input logic                  commit,
  input logic [NCH*DATA_W-1:0] wiper_bus
);
  logic [NCH*DATA_W-1:0] prev_bus;
  logic                  prev_commit, prev_ok;
  logic [NCH-1:0]        chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bus    <= {NCH{midscale()}};
      prev_commit <= 1'b0;
      prev_ok     <= 1'b0;
    end else begin
      prev_bus    <= wiper_bus;
      prev_commit <= commit;
      prev_ok     <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chg
    assign chg[c] = wiper_bus[c*DATA_W +: DATA_W] != prev_bus[c*DATA_W +: DATA_W];
  end

  a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && chg != '0) |-> prev_commit);
  a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> ($countones(chg) <= 1));
  a_r6_strap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    if_sel |-> !sdo_drive_low);
  a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !sdo_drive_low);
  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdo_bit) && !$past(if_sel) && !if_sel) |-> $past(sclk_fall || cs_fall));
endmodule

bind spiw_loader spiw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .sdo_drive_low(sdo_drive_low),
  .cs_active(cs_active), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
  .sdo_bit(sdo_bit), .commit(commit), .wiper_bus(wiper_bus));

// File: tb/spiw_loader_test.sv
module spiw_loader_test;
  localparam int HALF = 40;
  logic clk = 0, rst_n = 0, if_sel = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic sdo_drive_low;
  logic [31:0] wiper_bus;
  logic [7:0] exp_w [4];
  logic [9:0] sdo_seen;
  int checks = 0, failures = 0;

  spiw_loader uut (.clk(clk), .rst_n(rst_n), .if_sel(if_sel), .sclk(sclk),
    .cs_n(cs_n), .sdi(sdi), .sdo_drive_low(sdo_drive_low), .wiper_bus(wiper_bus));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_bus();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  // sends nbits of word (MSB of the 10-bit word first; extra bits are zero)
  task automatic send(input logic [9:0] word, input int nbits, input bit peek_before_rise);
    logic [10:0] ext;
    ext = {word, 1'b0};
    sdo_seen = '0;
    cs_n = 0;
    #HALF;
    for (int k = 0; k < nbits; k++) begin
      sdi = (k < 11) ? ext[10-k] : 1'b0;
      #HALF;
      if (k < 10) sdo_seen[9-k] = ~sdo_drive_low;
      sclk = 1;
      #HALF;
      sclk = 0;
    end
    #HALF;
    if (peek_before_rise) chk("R3 no write before select rises", wiper_bus, exp_bus());
    cs_n = 1;
    #(2*HALF);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 4; c++) exp_w[c] = 8'h80;
    chk("R5 reset midscale", wiper_bus, exp_bus());
    chk("R5 sdo released in reset", {31'b0, sdo_drive_low}, 32'd0);
  endtask

  task automatic t_map();
    send({2'b00, 8'h3C}, 10, 1'b1); exp_w[0] = 8'h3C;
    chk("R2 R9 channel 0", wiper_bus, exp_bus());
    send({2'b01, 8'hA5}, 10, 1'b0); exp_w[1] = 8'hA5;
    chk("R2 R9 channel 1", wiper_bus, exp_bus());
    send({2'b10, 8'h01}, 10, 1'b1); exp_w[2] = 8'h01;
    chk("R1 R2 channel 2 msb first", wiper_bus, exp_bus());
    send({2'b11, 8'hFE}, 10, 1'b0); exp_w[3] = 8'hFE;
    chk("R1 R2 channel 3", wiper_bus, exp_bus());
  endtask

  task automatic t_bad_count();
    send({2'b00, 8'h11}, 9, 1'b0);
    chk("R4 nine clocks ignored", wiper_bus, exp_bus());
    send({2'b01, 8'h22}, 11, 1'b0);
    chk("R4 eleven clocks ignored", wiper_bus, exp_bus());
  endtask

  task automatic t_strap();
    if_sel = 1;
    send({2'b10, 8'h77}, 10, 1'b0);
    chk("R6 strap high no write", wiper_bus, exp_bus());
    chk("R6 R8 sdo released under strap", {22'b0, sdo_seen}, 32'h3FF);
    if_sel = 0;
  endtask

  task automatic t_chain();
    send({2'b01, 8'h6D}, 10, 1'b0); exp_w[1] = 8'h6D;
    chk("R1 chain seed write", wiper_bus, exp_bus());
    send({2'b10, 8'hC3}, 10, 1'b0); exp_w[2] = 8'hC3;
    chk("R7 sdo carries previous frame", {22'b0, sdo_seen}, {22'b0, 2'b01, 8'h6D});
    chk("R8 released after frame", {31'b0, sdo_drive_low}, 32'd0);
    send({2'b00, 8'h00}, 10, 1'b0); exp_w[0] = 8'h00;
    chk("R7 second chain word", {22'b0, sdo_seen}, {22'b0, 2'b10, 8'hC3});
    chk("R9 write zero only channel 0", wiper_bus, exp_bus());
  endtask

  task automatic t_reset_again();
    #7 rst_n = 0;
    #20;
    for (int c = 0; c < 4; c++) exp_w[c] = 8'h80;
    chk("R5 reset during operation", wiper_bus, exp_bus());
    rst_n = 1;
    #40;
    chk("R5 midscale after release", wiper_bus, exp_bus());
  endtask

  initial begin
    #801;
    t_reset();
    rst_n = 1;
    #100;
    t_map();
    t_bad_count();
    t_strap();
    t_chain();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule